// File: doc/BRIEF.md
# Per-Chip DRAM Power Mode Manager

This block tracks and sets the power mode of every chip in a multi-chip DRAM array whose address space is not interleaved. The chip a request targets is taken from the upper bits of its physical address, so each chip owns one contiguous address range. Each chip runs its own controller. Traffic to one chip never changes the mode, timers or counts of another chip.

Under the quad-state policy, an idle chip steps down one mode at a time, Active to Standby to Nap to PowerDown. Each step happens once the chip has been idle for that mode's programmed threshold. Under the dual-state policy, a chip with no pending request drops directly to a shared base mode. In both policies, a request to a chip that is not Active is held off until a wake latency has elapsed. That latency depends on the mode the chip is waking from.

Thresholds and latencies are programmed in clock cycles. At 100 MHz, typical values are:
- idle thresholds of 0, 75 and 37 500 cycles;
- wake latencies of 1, 2 and 2 251 cycles.

Per-chip, per-mode residency counters let energy be computed outside the block. DRAM command timing and data movement are handled elsewhere.

Top module: `dram_pwr_mgr`

## Requirements
- R1: The target chip of a request or completion is `addr[ADDR_W-1:CAP_W]`. Chip i owns addresses i*2^CAP_W through (i+1)*2^CAP_W-1. NCHIP is a power of two. An access changes the mode of the addressed chip only.
- R2: Mode codes are 0 Active, 1 Standby, 2 Nap and 3 PowerDown. Chip i's mode is `chip_mode[2i+1:2i]`. While reset is low, every chip reads Active and every residency counter reads zero.
- R3: `req_grant` is combinational. It is high in the same cycle as `req_valid` when the addressed chip is Active, no wake is in progress, and its pending count is not at its maximum. Each accepted request adds one to that chip's pending count.
- R4: A request held on a chip in mode M (not Active) is refused for exactly W(M)+2 cycles and then granted, where W is `cfg_wake_sb`, `cfg_wake_nap` or `cfg_wake_pd` for Standby, Nap or PowerDown. The chip keeps mode M until it turns Active.
- R5: A completion subtracts one from the addressed chip's pending count. A completion to a chip with a zero count has no effect. A completion and an accepted request to the same chip in the same cycle leave the count unchanged.
- R6: With `cfg_quad`=1, an idle chip (pending zero, no request) stays T+1 cycles in Active, Standby and Nap, then drops one mode. T is `cfg_thr_act`, `cfg_thr_sb` or `cfg_thr_nap`, counted from the edge of the last accept, effective completion or mode change. PowerDown is kept until a request arrives.
- R7: A chip with a nonzero pending count stays Active under either policy.
- R8: With `cfg_quad`=0, an idle chip takes mode `cfg_base` (same codes as R2) at the next clock edge. A chip whose count reaches zero therefore reads Active for one cycle and then the base mode.
- R9: Counter (chip i, mode m) is `res_cnt[(4i+m)*CNT_W +: CNT_W]`. It adds one at each clock edge after reset at which chip i is in mode m. It saturates at 2^CNT_W-1, and at most one of a chip's counters moves per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until granted |
| req_addr | input | ADDR_W | Physical address of the request |
| req_grant | output | 1 | Request accepted this cycle |
| cpl_valid | input | 1 | One request has completed |
| cpl_addr | input | ADDR_W | Physical address of the completed request |
| cfg_quad | input | 1 | 1: threshold step-down policy, 0: base-mode policy |
| cfg_base | input | 2 | Base mode used by the dual-state policy |
| cfg_thr_act | input | TMR_W | Idle cycles before leaving Active |
| cfg_thr_sb | input | TMR_W | Idle cycles before leaving Standby |
| cfg_thr_nap | input | TMR_W | Idle cycles before leaving Nap |
| cfg_wake_sb | input | TMR_W | Wake latency from Standby |
| cfg_wake_nap | input | TMR_W | Wake latency from Nap |
| cfg_wake_pd | input | TMR_W | Wake latency from PowerDown |
| chip_mode | output | 2*NCHIP | Current mode of each chip |
| res_cnt | output | 4*NCHIP*CNT_W | Per-chip, per-mode residency counters |

## Verification
Assertions check the following on every cycle:
- a busy chip never leaves Active;
- a chip reaches Active only by completing a wake;
- the mode does not move during a wake;
- quad-state steps go down by at most one mode;
- completions never wrap the pending count;
- grants only ever reach Active chips;
- residency counters hold once saturated, and only one of a chip's counters advances per edge.

The exact dwell lengths, the refusal length for each source mode, and the independence across the address map are shown only by the bench's scenarios. The same holds for the dual-state return to the base mode and for counter totals checked against a mode trace kept by the bench.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'd0,
    PM_STANDBY = 2'd1,
    PM_NAP     = 2'd2,
    PM_PDOWN   = 2'd3
  } pwr_mode_e;

  localparam int unsigned NUM_MODES = 4;

endpackage

// File: rtl/pwr_chip_ctrl.sv
module pwr_chip_ctrl
  import pwr_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_hit,
  input  logic             cpl_hit,
  input  logic             cfg_quad,
  input  pwr_mode_e        cfg_base,
  input  logic [TMR_W-1:0] thr_act,
  input  logic [TMR_W-1:0] thr_sb,
  input  logic [TMR_W-1:0] thr_nap,
  input  logic [TMR_W-1:0] wake_sb,
  input  logic [TMR_W-1:0] wake_nap,
  input  logic [TMR_W-1:0] wake_pd,
  output logic             ready,
  output pwr_mode_e        mode
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              waking;
  logic [TMR_W-1:0]  tmr;
  logic [PEND_W-1:0] pend;

  // idle cycles allowed in mode m before stepping down
  function automatic logic [TMR_W-1:0] idle_limit(input pwr_mode_e m);
    case (m)
      PM_ACTIVE:  return thr_act;
      PM_STANDBY: return thr_sb;
      PM_NAP:     return thr_nap;
      default:    return '0;
    endcase
  endfunction

  // wake latency when leaving mode m for Active
  function automatic logic [TMR_W-1:0] wake_cost(input pwr_mode_e m);
    case (m)
      PM_STANDBY: return wake_sb;
      PM_NAP:     return wake_nap;
      PM_PDOWN:   return wake_pd;
      default:    return '0;
    endcase
  endfunction

  // named internal events
  logic      accept, cpl_eff, wake_start, wake_done, idle, step_down, go_base;
  pwr_mode_e mode_dn;

  assign ready      = (mode == PM_ACTIVE) && !waking && (pend != PEND_MAX);
  assign accept     = req_hit && ready;
  assign cpl_eff    = cpl_hit && (pend != '0);
  assign wake_start = req_hit && !waking && (mode != PM_ACTIVE);
  assign wake_done  = waking && (tmr == '0);
  assign idle       = !waking && !req_hit && (pend == '0);
  assign step_down  = idle && cfg_quad && (mode != PM_PDOWN) && (tmr == '0);
  assign go_base    = idle && !cfg_quad && (mode != cfg_base);
  assign mode_dn    = pwr_mode_e'(mode + 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= PM_ACTIVE;
      waking <= 1'b0;
      tmr    <= '0;
      pend   <= '0;
    end else begin
      case ({accept, cpl_eff})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase

      if (wake_start) begin
        waking <= 1'b1;
        tmr    <= wake_cost(mode);
      end else if (wake_done) begin
        waking <= 1'b0;
        mode   <= PM_ACTIVE;
        tmr    <= idle_limit(PM_ACTIVE);
      end else if (accept || cpl_eff) begin
        tmr <= idle_limit(mode);
      end else if (step_down) begin
        mode <= mode_dn;
        tmr  <= idle_limit(mode_dn);
      end else if (go_base) begin
        mode <= cfg_base;
        tmr  <= idle_limit(cfg_base);
      end else if (waking || (idle && cfg_quad && (mode != PM_PDOWN))) begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  AST_BUSY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> (mode == PM_ACTIVE)); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend == '0) && !accept) |=> (pend == '0)); // R5

  AST_WAKE_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (waking && (tmr != '0)) |=> $stable(mode)); // R4

  AST_RISE_VIA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PM_ACTIVE) |=> ((mode != PM_ACTIVE) || $past(waking))); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_quad && !waking) |=>
      ((mode == $past(mode)) || ({1'b0, mode} == ({1'b0, $past(mode)} + 3'd1)))); // R6

endmodule

// File: rtl/pwr_residency.sv
module pwr_residency
  import pwr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  pwr_mode_e                  mode,
  output logic [NUM_MODES*CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] mode_bits;
  assign mode_bits = mode;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    logic [CNT_W-1:0] c;
    logic             in_mode;
    logic             sat;

    assign in_mode = (mode_bits == 2'(m));
    assign sat     = (c == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                c <= '0;
      else if (in_mode && !sat)  c <= c + 1'b1;
    end

    assign cnt[m*CNT_W +: CNT_W] = c;

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sat |=> sat); // R9
  end

  AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones({g_mode[0].c != $past(g_mode[0].c),
                          g_mode[1].c != $past(g_mode[1].c),
                          g_mode[2].c != $past(g_mode[2].c),
                          g_mode[3].c != $past(g_mode[3].c)}) <= 1)); // R9

endmodule

// File: rtl/dram_pwr_mgr.sv
module dram_pwr_mgr
  import pwr_pkg::*;
#(
  parameter  int NCHIP  = 8,
  parameter  int CAP_W  = 12,
  parameter  int TMR_W  = 16,
  parameter  int CNT_W  = 32,
  parameter  int PEND_W = 4,
  localparam int CHIP_W = $clog2(NCHIP),
  localparam int ADDR_W = CAP_W + CHIP_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic [ADDR_W-1:0]                req_addr,
  output logic                             req_grant,
  input  logic                             cpl_valid,
  input  logic [ADDR_W-1:0]                cpl_addr,
  input  logic                             cfg_quad,
  input  logic [1:0]                       cfg_base,
  input  logic [TMR_W-1:0]                 cfg_thr_act,
  input  logic [TMR_W-1:0]                 cfg_thr_sb,
  input  logic [TMR_W-1:0]                 cfg_thr_nap,
  input  logic [TMR_W-1:0]                 cfg_wake_sb,
  input  logic [TMR_W-1:0]                 cfg_wake_nap,
  input  logic [TMR_W-1:0]                 cfg_wake_pd,
  output logic [2*NCHIP-1:0]               chip_mode,
  output logic [NUM_MODES*NCHIP*CNT_W-1:0] res_cnt
);

  logic [CHIP_W-1:0] req_chip, cpl_chip;
  logic [NCHIP-1:0]  chip_ready;
  pwr_mode_e         chip_m [NCHIP];
  pwr_mode_e         base_mode;

  // non-interleaved map: chip index is the address above the per-chip span
  assign req_chip  = req_addr[ADDR_W-1 -: CHIP_W];
  assign cpl_chip  = cpl_addr[ADDR_W-1 -: CHIP_W];
  assign base_mode = pwr_mode_e'(cfg_base);
  assign req_grant = req_valid && chip_ready[req_chip];

  for (genvar g = 0; g < NCHIP; g++) begin : g_chip
    logic req_hit, cpl_hit;
    assign req_hit = req_valid && (req_chip == CHIP_W'(g));
    assign cpl_hit = cpl_valid && (cpl_chip == CHIP_W'(g));

    pwr_chip_ctrl #(.TMR_W(TMR_W), .PEND_W(PEND_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_hit  (req_hit),
      .cpl_hit  (cpl_hit),
      .cfg_quad (cfg_quad),
      .cfg_base (base_mode),
      .thr_act  (cfg_thr_act),
      .thr_sb   (cfg_thr_sb),
      .thr_nap  (cfg_thr_nap),
      .wake_sb  (cfg_wake_sb),
      .wake_nap (cfg_wake_nap),
      .wake_pd  (cfg_wake_pd),
      .ready    (chip_ready[g]),
      .mode     (chip_m[g])
    );

    pwr_residency #(.CNT_W(CNT_W)) u_res (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (chip_m[g]),
      .cnt   (res_cnt[g*NUM_MODES*CNT_W +: NUM_MODES*CNT_W])
    );

    assign chip_mode[2*g +: 2] = chip_m[g];
  end

  AST_GRANT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |-> (chip_m[req_chip] == PM_ACTIVE)); // R3

endmodule

// File: tb/dram_pwr_mgr_tb.sv
module dram_pwr_mgr_tb;

  localparam int NCHIP  = 4;
  localparam int CAP_W  = 4;
  localparam int TMR_W  = 16;
  localparam int CNT_W  = 10;
  localparam int PEND_W = 4;
  localparam int ADDR_W = CAP_W + 2;
  localparam int SPAN   = 1 << CAP_W;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int T_ACT = 3, T_SB = 5, T_NAP = 7;
  localparam int W_SB  = 2, W_NAP = 4, W_PD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, cpl_valid = 1'b0, req_grant;
  logic [ADDR_W-1:0] req_addr = '0, cpl_addr = '0;
  logic cfg_quad = 1'b1;
  logic [1:0] cfg_base = 2'd2;
  logic [2*NCHIP-1:0] chip_mode;
  logic [4*NCHIP*CNT_W-1:0] res_cnt;

  always #5 clk = ~clk;

  dram_pwr_mgr #(.NCHIP(NCHIP), .CAP_W(CAP_W), .TMR_W(TMR_W), .CNT_W(CNT_W),
                 .PEND_W(PEND_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_grant(req_grant), .cpl_valid(cpl_valid), .cpl_addr(cpl_addr),
    .cfg_quad(cfg_quad), .cfg_base(cfg_base),
    .cfg_thr_act(TMR_W'(T_ACT)), .cfg_thr_sb(TMR_W'(T_SB)), .cfg_thr_nap(TMR_W'(T_NAP)),
    .cfg_wake_sb(TMR_W'(W_SB)), .cfg_wake_nap(TMR_W'(W_NAP)), .cfg_wake_pd(TMR_W'(W_PD)),
    .chip_mode(chip_mode), .res_cnt(res_cnt));

  int tests = 0, fails = 0;

  function automatic int mode_of(int ch);
    return int'(chip_mode[2*ch +: 2]);
  endfunction

  function automatic int res_of(int ch, int m);
    return int'(res_cnt[(ch*4+m)*CNT_W +: CNT_W]);
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // residency model kept from the observed mode trace
  int unsigned mdl [NCHIP][4];
  int          snap [NCHIP];
  logic        snap_ok = 1'b0;

  always @(negedge clk) begin
    snap_ok <= rst_n;
    for (int i = 0; i < NCHIP; i++) snap[i] <= mode_of(i);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCHIP; i++)
        for (int m = 0; m < 4; m++) mdl[i][m] = 0;
    end else if (snap_ok) begin
      for (int i = 0; i < NCHIP; i++)
        if (mdl[i][snap[i]] < CMAX) mdl[i][snap[i]]++;
    end
  end

  task automatic check_res(string tag);
    for (int i = 0; i < NCHIP; i++)
      for (int m = 0; m < 4; m++) check(tag, res_of(i, m), int'(mdl[i][m]));
  endtask

  // hold a request until granted; waits = refused cycles
  task automatic access(input int a, output int waits);
    waits = 0;
    req_valid = 1'b1;
    req_addr  = ADDR_W'(a);
    forever begin
      #1;
      if (req_grant) break;
      waits++;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic complete(input int a);
    cpl_valid = 1'b1;
    cpl_addr  = ADDR_W'(a);
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic dwell(input int ch, input int m, output int n);
    n = 0;
    while (mode_of(ch) == m && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  int w, n, stay;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NCHIP; i++) check("R2 reset mode", mode_of(i), 0);
    check_res("R2 reset counters");
    @(posedge clk);
    #2 rst_n = 1'b1;

    // quad-state: idle chips fall to PowerDown
    repeat (40) @(negedge clk);
    for (int i = 0; i < NCHIP; i++) check("R6 idle to PowerDown", mode_of(i), 3);

    access(0, w);     check("R4 wake from PowerDown", w, W_PD + 2);
    access(1, w);     check("R3 grant on Active chip", w, 0);
    complete(0);
    stay = 1;
    repeat (6) begin if (mode_of(0) != 0) stay = 0; @(negedge clk); end
    check("R7 busy chip stays Active", stay, 1);
    complete(0);
    dwell(0, 0, n);   check("R6 Active dwell", n, T_ACT + 1);
    dwell(0, 1, n);   check("R6 Standby dwell", n, T_SB + 1);
    dwell(0, 2, n);   check("R6 Nap dwell", n, T_NAP + 1);
    repeat (30) @(negedge clk);
    check("R6 PowerDown kept", mode_of(0), 3);

    access(2, w);  complete(2);
    repeat (T_ACT + 1) @(negedge clk);
    check("R6 in Standby", mode_of(0), 1);
    access(3, w);     check("R4 wake from Standby", w, W_SB + 2);
    complete(3);
    repeat (T_ACT + T_SB + 2) @(negedge clk);
    check("R6 in Nap", mode_of(0), 2);
    access(4, w);     check("R4 wake from Nap", w, W_NAP + 2);
    complete(4);

    // address map sweep: first and last address of every chip
    repeat (40) @(negedge clk);
    for (int ch = 0; ch < NCHIP; ch++) begin
      for (int k = 0; k < 2; k++) begin
        access(ch * SPAN + k * (SPAN - 1), w);
        check("R4 sweep wake", w, W_PD + 2);
        for (int j = 0; j < NCHIP; j++)
          check("R1 only target chip wakes", mode_of(j), (j == ch) ? 0 : 3);
        complete(ch * SPAN);
        repeat (25) @(negedge clk);
      end
    end

    // pending count corner cases on chip 3
    access(3 * SPAN, w);
    complete(3 * SPAN);
    complete(3 * SPAN + 1);
    repeat (30) @(negedge clk);
    check("R5 stray completion ignored", mode_of(3), 3);
    access(3 * SPAN, w);
    req_valid = 1'b1; req_addr = ADDR_W'(3 * SPAN + 2);
    cpl_valid = 1'b1; cpl_addr = ADDR_W'(3 * SPAN + 2);
    #1 check("R3 grant with same-cycle completion", int'(req_grant), 1);
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
    stay = 1;
    repeat (10) begin if (mode_of(3) != 0) stay = 0; @(negedge clk); end
    check("R5 count kept at one", stay, 1);
    complete(3 * SPAN);
    repeat (30) @(negedge clk);
    check("R5 count reached zero", mode_of(3), 3);

    // residency totals and saturation
    repeat (1100) @(negedge clk);
    check_res("R9 residency totals");
    check("R9 saturation", res_of(1, 3), CMAX);

    // dual-state policy
    cfg_quad = 1'b0; cfg_base = 2'd2;
    @(negedge clk);
    for (int i = 0; i < NCHIP; i++) check("R8 base Nap", mode_of(i), 2);
    access(SPAN, w);  check("R4 dual wake from Nap", w, W_NAP + 2);
    stay = 1;
    repeat (10) begin if (mode_of(1) != 0) stay = 0; @(negedge clk); end
    check("R7 dual busy Active", stay, 1);
    complete(SPAN);
    check("R8 Active one cycle after drain", mode_of(1), 0);
    @(negedge clk);
    check("R8 back to base", mode_of(1), 2);

    cfg_base = 2'd1;
    @(negedge clk);
    for (int i = 0; i < NCHIP; i++) check("R8 base Standby", mode_of(i), 1);
    access(0, w);     check("R4 dual wake from Standby", w, W_SB + 2);
    complete(0);
    @(negedge clk);
    check("R8 return to Standby", mode_of(0), 1);

    cfg_base = 2'd3;
    @(negedge clk);
    access(2 * SPAN, w);  check("R4 dual wake from PowerDown", w, W_PD + 2);
    complete(2 * SPAN);
    @(negedge clk);
    check("R8 return to PowerDown", mode_of(2), 3);

    repeat (5) @(negedge clk);
    check_res("R9 final residency");
    summary();
  end

endmodule